// File: doc/BRIEF.md
# Toggle-Handshake Single-Port RAM

This block is a synchronous single-port word memory for a sequencing controller, such as one produced by high-level synthesis. The controller does not use a chip-select level to ask for an access. It changes a user enable word so that it differs from the memory's own enable register. The memory treats any inequality between the two words as one pending request. At the next clock edge it performs exactly one access, either a write or a read. In the same edge it copies the user enable into its enable register, so the two words match again. The enable register is visible at a port, so the controller reads that match as the acknowledge.

The memory samples address, data, write enable and user enable at the edge. Anything the controller drives during a cycle therefore takes effect at the end of that cycle. The stored word, the read register and the enable register all change at that edge and can be seen one cycle later. Addresses are unsigned word indices. An index at or beyond the configured depth writes nothing and reads as zero. A synchronous reset clears the enable register and the read register and leaves the stored words as they are.

The handshake is a two-phase toggle, not a valid/ready stream. Back-pressure comes from the protocol itself: the controller must not raise a new request until the acknowledge matches its user enable. The memory always completes a request in one cycle, so the wait is one cycle at most.

Top module: `ths_ram`

## Requirements
- R1: While the enable register equals the user enable, no clock edge changes any stored word, the enable register or the read register, whatever the other inputs carry.
- R2: At an edge where the two enable words differ and the write-enable word is nonzero, the data input is stored at the addressed word.
- R3: At an edge where the two enable words differ and the write-enable word is zero, the addressed word is loaded into the read register. A write leaves the read register unchanged.
- R4: Every access loads the user enable into the enable register. One change of the user enable therefore yields exactly one access.
- R5: The stored word, the read register and the enable register change only at the clock edge. The inputs driven during a cycle have no visible effect before the edge that ends that cycle.
- R6: A write to an address at or beyond DEPTH changes no stored word, and that includes the word that a truncated index would alias to. A read from such an address loads zero.
- R7: A reset edge sets the enable register and the read register to zero and leaves every stored word unchanged.
- R8: A request is detected on a difference in any bit of the 32-bit enable words, including bit 31. Any nonzero write-enable word, including 32'h8000_0000, selects a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W (32) | Unsigned word index |
| wdata | input | DATA_W (32) | Data to store on a write |
| wr_sel | input | CTRL_W (32) | Nonzero selects a write, zero selects a read |
| req_tog | input | CTRL_W (32) | User enable; differing from ack_tog requests an access |
| ack_tog | output | CTRL_W (32) | Enable register; equals req_tog once the access is done |
| rdata | output | DATA_W (32) | Read register |

## Verification
The hardest situation to reach from the ports is a cycle in which the inputs look like a complete write but no request is pending, because the two enable words match. The stimulus holds the user enable equal to the acknowledge, drives several cycles of write-shaped traffic with fresh data, then issues a real read of that address and checks that it returns the old word. A second hard case is a request whose two enable words differ only in bit 31 and whose write-enable word has only bit 31 set. It is driven directly, and a read-back follows. Out-of-range writes use an address that aliases word zero when truncated, and word zero is checked afterwards.

// File: rtl/ths_ram_pkg.sv
package ths_ram_pkg;

  // Kind of access decided for the current edge
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ths_op_e;

  // Index width for a word array of the given depth (at least one bit)
  function automatic int idx_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/ths_req_detect.sv
module ths_req_detect
  import ths_ram_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic [CTRL_W-1:0] req_tog,
  input  logic [CTRL_W-1:0] ack_q,
  input  logic [CTRL_W-1:0] wr_sel,
  output ths_op_e           op
);

  logic pending;
  logic is_write;

  // Any bit difference means a request is outstanding
  assign pending  = |(req_tog ^ ack_q);
  assign is_write = |wr_sel;

  always_comb begin
    if (!pending)      op = OP_IDLE;
    else if (is_write) op = OP_WRITE;
    else               op = OP_READ;
  end

endmodule

// File: rtl/ths_ack_reg.sv
module ths_ack_reg
  import ths_ram_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ths_op_e           op,
  input  logic [CTRL_W-1:0] req_tog,
  output logic [CTRL_W-1:0] ack_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= '0;
    end else if (op != OP_IDLE) begin
      ack_q <= req_tog;
    end
  end

endmodule

// File: rtl/ths_mem_array.sv
module ths_mem_array
  import ths_ram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ths_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int IDX_W = idx_width(DEPTH);

  logic [DATA_W-1:0] words [DEPTH];
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] fetch;

  assign in_range = (addr < ADDR_W'(DEPTH));
  assign idx      = addr[IDX_W-1:0];
  assign fetch    = in_range ? words[idx] : '0;

  // Storage: no reset so contents survive it
  always_ff @(posedge clk) begin
    if (!rst && op == OP_WRITE && in_range) begin
      words[idx] <= wdata;
    end
  end

  // Read register
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (op == OP_READ) begin
      rdata <= fetch;
    end
  end

endmodule

// File: rtl/ths_ram.sv
module ths_ram
  import ths_ram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CTRL_W-1:0] wr_sel,
  input  logic [CTRL_W-1:0] req_tog,
  output logic [CTRL_W-1:0] ack_tog,
  output logic [DATA_W-1:0] rdata
);

  ths_op_e op;

  ths_req_detect #(.CTRL_W(CTRL_W)) u_detect (
    .req_tog (req_tog),
    .ack_q   (ack_tog),
    .wr_sel  (wr_sel),
    .op      (op)
  );

  ths_ack_reg #(.CTRL_W(CTRL_W)) u_ack (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .req_tog (req_tog),
    .ack_q   (ack_tog)
  );

  ths_mem_array #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

endmodule

// File: rtl/ths_ram_chk.sv
module ths_ram_chk #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [CTRL_W-1:0] wr_sel,
  input logic [CTRL_W-1:0] req_tog,
  input logic [CTRL_W-1:0] ack_tog,
  input logic [DATA_W-1:0] rdata
);

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (ack_tog == req_tog) |=> ($stable(ack_tog) && $stable(rdata)));

  a_r4_ack_copies: assert property (@(posedge clk) disable iff (rst)
    (ack_tog != req_tog) |=> (ack_tog == $past(req_tog)));

  a_r3_write_keeps_rdata: assert property (@(posedge clk) disable iff (rst)
    ((ack_tog != req_tog) && (wr_sel != '0)) |=> $stable(rdata));

  a_r6_oor_read_zero: assert property (@(posedge clk) disable iff (rst)
    ((ack_tog != req_tog) && (wr_sel == '0) && (addr >= ADDR_W'(DEPTH)))
      |=> (rdata == '0));

  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> ((ack_tog == '0) && (rdata == '0)));

endmodule

bind ths_ram ths_ram_chk #(
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CTRL_W (CTRL_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_sel  (wr_sel),
  .req_tog (req_tog),
  .ack_tog (ack_tog),
  .rdata   (rdata)
);

// File: tb/ths_ram_tb_top.sv
module ths_ram_tb_top;

  localparam int DEPTH = 256;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;   // write data, or expected read value
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 32'd5,   32'hAAAA_0005},
    '{1'b1, 32'd6,   32'h1234_5678},
    '{1'b0, 32'd5,   32'hAAAA_0005},
    '{1'b0, 32'd6,   32'h1234_5678},
    '{1'b1, 32'd255, 32'hDEAD_BEEF},
    '{1'b0, 32'd255, 32'hDEAD_BEEF},
    '{1'b1, 32'd0,   32'h0000_0001},
    '{1'b0, 32'd0,   32'h0000_0001},
    '{1'b1, 32'd5,   32'hFFFF_FFFF},
    '{1'b0, 32'd5,   32'hFFFF_FFFF},
    '{1'b0, 32'd6,   32'h1234_5678},
    '{1'b1, 32'd256, 32'hBAD0_0000},
    '{1'b0, 32'd256, 32'h0000_0000},
    '{1'b0, 32'd0,   32'h0000_0001}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] addr, wdata, wr_sel, req_tog;
  logic [31:0] ack_tog, rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] ref_mem [DEPTH];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;   // 50 MHz

  ths_ram #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .wr_sel(wr_sel), .req_tog(req_tog), .ack_tog(ack_tog), .rdata(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request: drive at negedge, edge performs it, observe at next negedge
  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [31:0] flip, input logic [31:0] wsel);
    logic [31:0] new_tog;
    logic [31:0] old_rd;
    @(negedge clk);
    old_rd  = rdata;
    addr    = a;
    wdata   = d;
    wr_sel  = wr ? wsel : 32'd0;
    new_tog = ack_tog ^ flip;
    req_tog = new_tog;
    #1;
    chk("R5 ack before edge", ack_tog, new_tog ^ flip);
    chk("R5 rdata before edge", rdata, old_rd);
    @(negedge clk);
    chk("R4 ack follows request", ack_tog, new_tog);
    if (wr) chk("R3 write keeps rdata", rdata, old_rd);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    access(1'b1, a, d, 32'h1, 32'h1);
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] v);
    access(1'b0, a, 32'h0, 32'h1, 32'h1);
    v = rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; addr = '0; wdata = '0; wr_sel = '0; req_tog = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset ack", ack_tog, 32'd0);
    chk("R7 reset rdata", rdata, 32'd0);
    rst = 1'b0;

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) do_write(VECS[i].addr, VECS[i].data);
      else begin
        do_read(VECS[i].addr, v);
        chk("R3 R6 table read", v, VECS[i].data);
      end
    end

    // R1: write-shaped traffic while enables match
    @(negedge clk);
    req_tog = ack_tog; addr = 32'd6; wdata = 32'h5555_AAAA; wr_sel = 32'hFFFF_FFFF;
    for (int k = 0; k < 4; k++) begin
      v = rdata;
      @(negedge clk);
      wdata = wdata + 32'd1;
      chk("R1 idle ack stable", ack_tog, req_tog);
      chk("R1 idle rdata stable", rdata, v);
    end
    do_read(32'd6, v);
    chk("R1 idle wrote nothing", v, 32'h1234_5678);

    // R8: bit-31 difference and bit-31-only write select
    access(1'b1, 32'd7, 32'hC0FF_EE00, 32'h8000_0000, 32'h8000_0000);
    do_read(32'd7, v);
    chk("R8 bit31 request write", v, 32'hC0FF_EE00);
    access(1'b0, 32'd5, 32'h0, 32'h8000_0000, 32'h0);
    chk("R8 bit31 request read", rdata, 32'hFFFF_FFFF);

    // R6: far out-of-range address
    do_write(32'hFFFF_FFFF, 32'h0BAD_0BAD);
    do_read(32'hFFFF_FFFF, v);
    chk("R6 oor read zero", v, 32'd0);
    do_read(32'd255, v);
    chk("R6 oor no alias", v, 32'hDEAD_BEEF);

    // R7: reset mid-run keeps contents
    do_read(32'd5, v);
    @(negedge clk); rst = 1'b1; req_tog = ack_tog;
    @(negedge clk); rst = 1'b0;
    chk("R7 reset ack clear", ack_tog, 32'd0);
    chk("R7 reset rdata clear", rdata, 32'd0);
    req_tog = 32'd0;
    do_read(32'd5, v);
    chk("R7 contents kept", v, 32'hFFFF_FFFF);

    // Randomized phase against reference array
    for (int a = 0; a < DEPTH; a++) begin
      ref_mem[a] = 32'h3C00_0000 ^ a;
      do_write(a, ref_mem[a]);
    end
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ra;
      logic [31:0] rd;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = 32'(lfsr[8:0] % (DEPTH + 8));
      rd = {lfsr, lfsr ^ 16'h5A5A};
      if (lfsr[15]) begin
        do_write(ra, rd);
        if (ra < DEPTH) ref_mem[ra] = rd;
      end else begin
        do_read(ra, v);
        chk("R2 R3 random read", v, (ra < DEPTH) ? ref_mem[ra] : 32'd0);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule